// File: doc/BRIEF.md
# Partially Guarded Two's Complement Adder

This block adds two signed operands. The adder is cut into a lower slice and an upper slice. For each transaction a range check looks at the operands. It decides whether the lower slice alone can produce the answer. That holds when both operands and their sum lie inside the signed range of the lower slice.

When the lower slice is enough, level-sensitive holding latches on the upper-slice operand inputs stay closed. The upper adder then sees no input toggles. The upper half of the result is rebuilt by copying the sign bit of the lower sum. When the range check fails, the latches open, the upper adder takes the carry from the lower slice, and the full-width sum is used.

The result is bit-identical to a plain full-width add in every case. A flag reports which path produced the result.

Transactions enter on a valid/ready handshake and leave on a valid/ready handshake, with one register stage between them. An operand pair is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The result appears one cycle later. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled consumer therefore stops new input at once. No transaction is dropped or duplicated.

Top module: `pga_add`

## Requirements
- R1: For every accepted pair, `sum` equals `(op_a + op_b)` modulo 2^W.
- R2: `msp_off` is 1 exactly when three values all lie in the signed range of the lower LW bits (-2^(LW-1) to 2^(LW-1)-1): `op_a`, `op_b` and their sum. In that case bits W-1 down to LW-1 of each operand are all equal. Otherwise `msp_off` is 0.
- R3: When `msp_off` is 1, every bit of `sum` from LW upward equals `sum[LW-1]`.
- R4: During lower-only transactions the upper-slice operand latches hold their contents. They become transparent again for the next full-width transaction, so a full-width add that follows any run of lower-only adds is still exact.
- R5: A pair accepted on a clock edge is presented with `out_valid` high after that edge. `in_ready` is high when `out_valid` is low or `out_ready` is high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `sum` and `msp_off` hold, and `in_ready` is low, so offered inputs are not taken.
- R7: During and after an active-low reset, `out_valid`, `sum` and `msp_off` are 0.
- R8: Once a result is drained and `in_valid` is low, `out_valid` falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take the pair this cycle |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| sum | output | W | Two's complement sum |
| msp_off | output | 1 | Result came from the lower slice alone |

## Verification
The bench builds the adder 12 bits wide with a 5-bit lower slice. This puts the guarded range at -16 to 15 and makes an uneven cut between the slices. With this size, hand-worked operands reach the edges of the range:
- the ends of that window;
- sums that leave it by one;
- operands whose upper bits are only partly sign copies;
- the full-width overflow corner.

Directed sequences cover several points:
- runs of guarded adds followed by a full add;
- a consumer stall with a new pair waiting;
- draining to idle.

// File: rtl/pga_pkg.sv
package pga_pkg;

  // Which slice combination produced a result
  typedef enum logic {
    PATH_FULL = 1'b0,
    PATH_LOW  = 1'b1
  } pga_path_e;

  // Output register contents
  typedef struct packed {
    logic      valid;
    pga_path_e path;
  } pga_ctl_t;

endpackage

// File: rtl/pga_range_detect.sv
module pga_range_detect #(
  parameter int W  = 32,
  parameter int LW = 16
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [LW-1:0] low_sum,
  output logic          low_only
);
  localparam int TW = W - LW + 1;  // bits that must be sign copies

  logic [1:0] fits;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic [TW-1:0] top;
    assign top     = (g == 0) ? op_a[W-1:LW-1] : op_b[W-1:LW-1];
    assign fits[g] = (&top) | ~(|top);
  end

  logic low_ovf;
  assign low_ovf  = (op_a[LW-1] == op_b[LW-1]) && (low_sum[LW-1] != op_a[LW-1]);
  assign low_only = (&fits) & ~low_ovf;
endmodule

// File: rtl/pga_slice_add.sv
module pga_slice_add #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] s
);
  assign s = a + b + {{(SW-1){1'b0}}, cin};
endmodule

// File: rtl/pga_msp_guard.sv
module pga_msp_guard #(
  parameter int MW = 16
) (
  input  logic          open_en,
  input  logic [MW-1:0] a_d,
  input  logic [MW-1:0] b_d,
  output logic [MW-1:0] a_q,
  output logic [MW-1:0] b_q
);
  // Transparent while open_en is high, frozen otherwise
  always_latch begin
    if (open_en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end
endmodule

// File: rtl/pga_add.sv
module pga_add
  import pga_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] sum,
  output logic         msp_off
);
  localparam int MW = W - LW;

  logic          accept;
  logic [LW:0]   low_res;   // carry in top bit
  logic [LW-1:0] low_sum;
  logic          low_cy;
  logic          low_only;
  logic          guard_en;
  logic [MW-1:0] msp_a_q, msp_b_q;
  logic [MW-1:0] msp_sum;
  logic [W-1:0]  res;
  pga_ctl_t      ctl_q;

  assign in_ready = ~ctl_q.valid | out_ready;
  assign accept   = in_valid & in_ready;

  pga_slice_add #(.SW(LW + 1)) u_low (
    .a   ({1'b0, op_a[LW-1:0]}),
    .b   ({1'b0, op_b[LW-1:0]}),
    .cin (1'b0),
    .s   (low_res)
  );
  assign low_sum = low_res[LW-1:0];
  assign low_cy  = low_res[LW];

  pga_range_detect #(.W(W), .LW(LW)) u_detect (
    .op_a     (op_a),
    .op_b     (op_b),
    .low_sum  (low_sum),
    .low_only (low_only)
  );

  assign guard_en = accept & ~low_only;

  pga_msp_guard #(.MW(MW)) u_guard (
    .open_en (guard_en),
    .a_d     (op_a[W-1:LW]),
    .b_d     (op_b[W-1:LW]),
    .a_q     (msp_a_q),
    .b_q     (msp_b_q)
  );

  pga_slice_add #(.SW(MW)) u_high (
    .a   (msp_a_q),
    .b   (msp_b_q),
    .cin (low_cy),
    .s   (msp_sum)
  );

  assign res = low_only ? {{MW{low_sum[LW-1]}}, low_sum} : {msp_sum, low_sum};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{valid: 1'b0, path: PATH_FULL};
      sum   <= '0;
    end else if (accept) begin
      ctl_q <= '{valid: 1'b1, path: low_only ? PATH_LOW : PATH_FULL};
      sum   <= res;
    end else if (out_ready) begin
      ctl_q.valid <= 1'b0;
    end
  end

  assign out_valid = ctl_q.valid;
  assign msp_off   = (ctl_q.path == PATH_LOW);
endmodule

// File: rtl/pga_add_chk.sv
module pga_add_chk #(
  parameter int W  = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  sum,
  input logic          msp_off,
  input logic          guard_en,
  input logic [W-LW-1:0] msp_a_q
);
  logic [W-1:0] add_w;
  logic         fit_w;
  logic         acc_w;

  assign acc_w = in_valid && in_ready;
  assign add_w = op_a + op_b;
  assign fit_w = ({{(W-LW){op_a[LW-1]}}, op_a[LW-1:0]} == op_a) &&
                 ({{(W-LW){op_b[LW-1]}}, op_b[LW-1:0]} == op_b) &&
                 ({{(W-LW){add_w[LW-1]}}, add_w[LW-1:0]} == add_w);

  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> (sum == $past(add_w)));

  p_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> (msp_off == $past(fit_w)));

  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && msp_off) |-> (sum == {{(W-LW){sum[LW-1]}}, sum[LW-1:0]}));

  p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    guard_en |-> (msp_a_q == op_a[W-1:LW]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!guard_en && $past(!guard_en)) |-> $stable(msp_a_q));

  p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> out_valid);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(sum) && $stable(msp_off)));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind pga_add pga_add_chk #(.W(W), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .sum       (sum),
  .msp_off   (msp_off),
  .guard_en  (guard_en),
  .msp_a_q   (msp_a_q)
);

// File: tb/pga_add_bench.sv
module pga_add_bench;
  localparam int BW = 12;
  localparam int BL = 5;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b1;
  logic [BW-1:0] op_a = '0;
  logic [BW-1:0] op_b = '0;
  logic          in_ready, out_valid, msp_off;
  logic [BW-1:0] sum;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pga_add #(.W(BW), .LW(BL)) u_pga_add (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .op_a (op_a), .op_b (op_b), .out_valid (out_valid), .out_ready (out_ready),
    .sum (sum), .msp_off (msp_off)
  );

  // {a, b, expected msp_off}
  localparam logic [2*BW:0] VEC [NV] = '{
    {12'h003, 12'h004, 1'b1},
    {12'h00F, 12'h001, 1'b0},
    {12'hFF0, 12'h000, 1'b1},
    {12'hFF0, 12'hFFF, 1'b0},
    {12'h010, 12'hFF0, 1'b0},
    {12'h7FF, 12'h001, 1'b0},
    {12'hFFF, 12'hFFF, 1'b1},
    {12'h00F, 12'hFF0, 1'b1},
    {12'h800, 12'h800, 1'b0},
    {12'h00A, 12'h005, 1'b1},
    {12'hFF8, 12'hFF8, 1'b1},
    {12'hFF7, 12'hFF7, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [BW-1:0] a, input logic [BW-1:0] b, input logic off);
    logic [BW-1:0] e;
    e = a + b;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R5 out_valid", 32'(out_valid), 32'd1);
    chk(sum == e, "R1 sum", 32'(sum), 32'(e));
    chk(msp_off == off, "R2 msp_off", 32'(msp_off), 32'(off));
    if (off)
      chk(sum[BW-1:BL] == {(BW-BL){sum[BL-1]}}, "R3 sign copy", 32'(sum), 32'(e));
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R7: reset state
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid", 32'(out_valid), 32'd0);
    chk(sum == '0, "R7 sum", 32'(sum), 32'd0);
    chk(msp_off == 1'b0, "R7 msp_off", 32'(msp_off), 32'd0);
    chk(in_ready == 1'b1, "R5 in_ready idle", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][2*BW:BW+1], VEC[i][BW:1], VEC[i][0]);

    // R8: drained with no input
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle", 32'(out_valid), 32'd0);

    // R4: guarded run then a full add with new upper bits
    do_op(12'h005, 12'h003, 1'b1);
    do_op(12'hFFE, 12'h001, 1'b1);
    do_op(12'h3A0, 12'h0C5, 1'b0);
    chk(sum == 12'h465, "R4 full after guarded", 32'(sum), 32'h465);

    // R6: back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; op_a = 12'h003; op_b = 12'h002;
    @(negedge clk);
    op_a = 12'h123; op_b = 12'h456;
    chk(out_valid == 1'b1, "R5 stalled valid", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0, "R6 in_ready low", 32'(in_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(sum == 12'h005, "R6 sum held", 32'(sum), 32'h005);
      chk(msp_off == 1'b1, "R6 flag held", 32'(msp_off), 32'd1);
      chk(in_ready == 1'b0, "R6 input blocked", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R6 next valid", 32'(out_valid), 32'd1);
    chk(sum == 12'h579, "R6 pending taken", 32'(sum), 32'h579);
    chk(msp_off == 1'b0, "R2 pending flag", 32'(msp_off), 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 drained", 32'(out_valid), 32'd0);

    // R7: reset mid-stream
    do_op(12'h7FF, 12'h7FF, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && sum == '0, "R7 reset again", 32'(sum), 32'd0);
    finish_run();
  end
endmodule